// File: doc/BRIEF.md
# Dual-Channel Phase Comparator with Lock Monitor

This block compares, for each of two synthesizer loops, a reference pulse train against the divided oscillator pulse train. Both trains arrive as one-cycle strobes in the reference-oscillator clock domain. For each loop it produces two charge-pump controls: source current and sink current. Both low means the pump output floats. The polarity of the loop filter can be set per loop. A short pulse on both controls marks every comparison, so the pump never sits in a dead zone.

Each loop has its own lock judge. The judge measures every comparison's timing error in whole oscillator cycles. It drops lock on a large error. It grants lock only after a run of three consecutive small errors. A loop in power-save floats its pump controls and forgets its lock state. On waking, its first comparison only realigns the detector.

The two lock states are merged into one flag, and a sleeping loop counts as locked. A single monitor pin shows either the merged flag or one of the four raw pulse trains. A per-loop current-level bit is passed straight through for the analog pump.

Top module: `pd_dual_lock`

## Requirements
- R1: With polarity 1, a reference strobe that comes E ≥ 1 cycles before the divided strobe holds the source control high (sink low) for E sampled cycles, starting the cycle after the reference strobe.
- R2: With polarity 1, a divided strobe that comes E ≥ 1 cycles first holds the sink control high (source low) for E cycles. In both this case and R1, one cycle with both controls high follows, and then both go low.
- R3: With polarity 0, the roles of source and sink in R1 and R2 are swapped; the both-high cycle is unchanged.
- R4: Strobes in the same cycle give exactly one cycle with both controls high and no single-sided cycle. With no comparison in progress, both controls are low (floating).
- R5: While a loop's sleep input is high, its source and sink controls stay low whatever strobes arrive, and its lock state is cleared.
- R6: The first comparison that completes after sleep is released produces no pump activity and is not judged. Later comparisons behave as in R1 to R4.
- R7: A comparison's error is the number of cycles between the two strobes. An error of at most LOCK_WIN (default 1) counts toward a run. After the third consecutive such comparison, the loop is locked in the cycle that follows the completing strobe.
- R8: An error of at least UNLOCK_WIN (default 3) clears lock and the run. An error between the two windows clears the run but leaves lock as it was.
- R9: `lock_all` is high exactly when each loop is either locked or has its sleep input high.
- R10: With `lds` = 0, `mon` equals `lock_all`. With `lds` = 1, `mon` shows the strobe chosen by `tsel`: 0 loop-A reference, 1 loop-B reference, 2 loop-A divided, 3 loop-B divided.
- R11: `cur_hi_a` and `cur_hi_b` follow `cs_a` and `cs_b` directly.
- R12: After synchronous reset, all pump controls and `lock_all` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fr_a | input | 1 | Loop A reference strobe |
| fp_a | input | 1 | Loop A divided strobe |
| fr_b | input | 1 | Loop B reference strobe |
| fp_b | input | 1 | Loop B divided strobe |
| sleep_a | input | 1 | Loop A power-save |
| sleep_b | input | 1 | Loop B power-save |
| pol_a | input | 1 | Loop A polarity (1: reference lead sources) |
| pol_b | input | 1 | Loop B polarity |
| cs_a | input | 1 | Loop A current-level bit |
| cs_b | input | 1 | Loop B current-level bit |
| lds | input | 1 | Monitor mode: 0 lock, 1 pulse tap |
| tsel | input | 2 | Pulse tap select |
| src_a | output | 1 | Loop A source-current control |
| snk_a | output | 1 | Loop A sink-current control |
| src_b | output | 1 | Loop B source-current control |
| snk_b | output | 1 | Loop B sink-current control |
| cur_hi_a | output | 1 | Loop A current-level flag |
| cur_hi_b | output | 1 | Loop B current-level flag |
| lock_all | output | 1 | Merged lock flag |
| mon | output | 1 | Monitor output |

## Verification
Each loop is swept over signed strobe offsets from -6 to +6 cycles under both polarities. The counts of source-only, sink-only and both-high cycles are compared with the offset magnitude. This separates lead direction, polarity swap and the anti-dead-zone pulse. The same sweep runs the error sequence through the far, middle and near bands, so lock loss, streak break and lock grant each occur against an arithmetic model. Sleep and wake sequences show the silent resync comparison and the merged flag's treatment of sleeping loops. All sixteen strobe patterns are applied under each tap select.

// File: rtl/pd_pkg.sv
package pd_pkg;

    typedef struct packed {
        logic src;
        logic snk;
    } pump_t;

    typedef enum logic [1:0] {
        TAP_REF_A = 2'd0,
        TAP_REF_B = 2'd1,
        TAP_DIV_A = 2'd2,
        TAP_DIV_B = 2'd3
    } tap_e;

    typedef enum logic [1:0] {
        V_NEAR = 2'd0,
        V_MID  = 2'd1,
        V_FAR  = 2'd2
    } verdict_e;

    function automatic verdict_e classify(input int unsigned err,
                                          input int unsigned near_max,
                                          input int unsigned far_min);
        if (err >= far_min)
            return V_FAR;
        else if (err <= near_max)
            return V_NEAR;
        else
            return V_MID;
    endfunction

    function automatic pump_t apply_pol(input pump_t raw, input logic pol);
        pump_t o;
        o.src = pol ? raw.src : raw.snk;
        o.snk = pol ? raw.snk : raw.src;
        return o;
    endfunction

endpackage

// File: rtl/pd_edge_core.sv
module pd_edge_core #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             quiet,
    input  logic             ref_p,
    input  logic             div_p,
    output logic             ref_lead,
    output logic             div_lead,
    output logic             dz,
    output logic             done,
    output logic [ERR_W-1:0] err
);
    logic             ref_q, div_q, dz_q;
    logic [ERR_W-1:0] cnt_q;
    logic             ref_any, div_any;
    logic [ERR_W:0]   sum;

    assign ref_any = ref_q | ref_p;
    assign div_any = div_q | div_p;
    assign done    = !hold && ref_any && div_any;
    assign sum     = {1'b0, cnt_q} + {{ERR_W{1'b0}}, (ref_q | div_q)};
    assign err     = sum[ERR_W] ? '1 : sum[ERR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            ref_q <= 1'b0;
            div_q <= 1'b0;
            dz_q  <= 1'b0;
            cnt_q <= '0;
        end else if (done) begin
            ref_q <= 1'b0;
            div_q <= 1'b0;
            dz_q  <= !quiet;
            cnt_q <= '0;
        end else begin
            ref_q <= ref_any;
            div_q <= div_any;
            dz_q  <= 1'b0;
            if ((ref_q ^ div_q) && (cnt_q != '1))
                cnt_q <= cnt_q + ERR_W'(1);
        end
    end

    assign ref_lead = ref_q;
    assign div_lead = div_q;
    assign dz       = dz_q;

    // R1
    single_lead_chk: assert property (@(posedge clk) disable iff (rst)
        !(ref_q && div_q));

    // R4
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        !(ref_q || div_q) |-> (cnt_q == '0));

endmodule

// File: rtl/pd_lock_judge.sv
module pd_lock_judge
    import pd_pkg::*;
#(
    parameter int ERR_W      = 8,
    parameter int LOCK_WIN   = 1,
    parameter int UNLOCK_WIN = 3,
    parameter int LOCK_RUNS  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             judge,
    input  logic [ERR_W-1:0] err,
    output logic             locked
);
    localparam int RUN_W = $clog2(LOCK_RUNS + 1);

    logic [RUN_W-1:0] run_q;
    logic             locked_q;
    verdict_e         verdict;

    assign verdict = classify(32'(err), LOCK_WIN, UNLOCK_WIN);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            run_q    <= '0;
            locked_q <= 1'b0;
        end else if (judge) begin
            unique case (verdict)
                V_FAR: begin
                    run_q    <= '0;
                    locked_q <= 1'b0;
                end
                V_MID: begin
                    run_q <= '0;
                end
                default: begin
                    if (run_q != RUN_W'(LOCK_RUNS))
                        run_q <= run_q + RUN_W'(1);
                    if (run_q >= RUN_W'(LOCK_RUNS - 1))
                        locked_q <= 1'b1;
                end
            endcase
        end
    end

    assign locked = locked_q;

    // R8
    far_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (judge && (err >= ERR_W'(UNLOCK_WIN))) |=> !locked_q);

    // R7
    lock_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> ($past(run_q) >= RUN_W'(LOCK_RUNS - 1)));

    // R5
    sleep_clear_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> !locked_q);

endmodule

// File: rtl/pd_channel.sv
module pd_channel
    import pd_pkg::*;
#(
    parameter int ERR_W      = 8,
    parameter int LOCK_WIN   = 1,
    parameter int UNLOCK_WIN = 3,
    parameter int LOCK_RUNS  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep,
    input  logic pol,
    input  logic fr,
    input  logic fp,
    output logic src,
    output logic snk,
    output logic locked
);
    logic             mute_q;
    logic             ref_lead, div_lead, dz, core_done;
    logic [ERR_W-1:0] core_err;
    pump_t            raw, pump_o;

    pd_edge_core #(.ERR_W(ERR_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .hold    (sleep),
        .quiet   (mute_q),
        .ref_p   (fr),
        .div_p   (fp),
        .ref_lead(ref_lead),
        .div_lead(div_lead),
        .dz      (dz),
        .done    (core_done),
        .err     (core_err)
    );

    pd_lock_judge #(
        .ERR_W     (ERR_W),
        .LOCK_WIN  (LOCK_WIN),
        .UNLOCK_WIN(UNLOCK_WIN),
        .LOCK_RUNS (LOCK_RUNS)
    ) u_judge (
        .clk   (clk),
        .rst   (rst),
        .hold  (sleep),
        .judge (core_done && !mute_q),
        .err   (core_err),
        .locked(locked)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mute_q <= 1'b0;
        else if (sleep)
            mute_q <= 1'b1;
        else if (core_done)
            mute_q <= 1'b0;
    end

    always_comb begin
        raw.src = ref_lead | dz;
        raw.snk = div_lead | dz;
        if (sleep || mute_q)
            pump_o = '0;
        else
            pump_o = apply_pol(raw, pol);
    end

    assign src = pump_o.src;
    assign snk = pump_o.snk;

    // R6
    wake_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep) |-> !(pump_o.src || pump_o.snk));

    // R4
    both_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (pump_o.src && pump_o.snk) |-> $past(core_done));

endmodule

// File: rtl/pd_mon_mux.sv
module pd_mon_mux
    import pd_pkg::*;
(
    input  logic       lock_all,
    input  logic       lds,
    input  logic [1:0] tsel,
    input  logic [1:0] fr_v,
    input  logic [1:0] fp_v,
    output logic       mon
);
    logic tap;

    always_comb begin
        unique case (tap_e'(tsel))
            TAP_REF_A: tap = fr_v[0];
            TAP_REF_B: tap = fr_v[1];
            TAP_DIV_A: tap = fp_v[0];
            default:   tap = fp_v[1];
        endcase
        mon = lds ? tap : lock_all;
    end

endmodule

// File: rtl/pd_dual_lock.sv
module pd_dual_lock #(
    parameter int ERR_W      = 8,
    parameter int LOCK_WIN   = 1,
    parameter int UNLOCK_WIN = 3,
    parameter int LOCK_RUNS  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fr_a,
    input  logic       fp_a,
    input  logic       fr_b,
    input  logic       fp_b,
    input  logic       sleep_a,
    input  logic       sleep_b,
    input  logic       pol_a,
    input  logic       pol_b,
    input  logic       cs_a,
    input  logic       cs_b,
    input  logic       lds,
    input  logic [1:0] tsel,
    output logic       src_a,
    output logic       snk_a,
    output logic       src_b,
    output logic       snk_b,
    output logic       cur_hi_a,
    output logic       cur_hi_b,
    output logic       lock_all,
    output logic       mon
);
    localparam int NCH = 2;

    logic [NCH-1:0] fr_v, fp_v, sl_v, pol_v;
    logic [NCH-1:0] src_v, snk_v, lk_v, ok_v;

    assign fr_v  = {fr_b, fr_a};
    assign fp_v  = {fp_b, fp_a};
    assign sl_v  = {sleep_b, sleep_a};
    assign pol_v = {pol_b, pol_a};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pd_channel #(
            .ERR_W     (ERR_W),
            .LOCK_WIN  (LOCK_WIN),
            .UNLOCK_WIN(UNLOCK_WIN),
            .LOCK_RUNS (LOCK_RUNS)
        ) u_ch (
            .clk   (clk),
            .rst   (rst),
            .sleep (sl_v[c]),
            .pol   (pol_v[c]),
            .fr    (fr_v[c]),
            .fp    (fp_v[c]),
            .src   (src_v[c]),
            .snk   (snk_v[c]),
            .locked(lk_v[c])
        );
        assign ok_v[c] = lk_v[c] | sl_v[c];
    end

    assign lock_all = &ok_v;
    assign src_a    = src_v[0];
    assign snk_a    = snk_v[0];
    assign src_b    = src_v[1];
    assign snk_b    = snk_v[1];
    assign cur_hi_a = cs_a;
    assign cur_hi_b = cs_b;

    pd_mon_mux u_mon (
        .lock_all(lock_all),
        .lds     (lds),
        .tsel    (tsel),
        .fr_v    (fr_v),
        .fp_v    (fp_v),
        .mon     (mon)
    );

endmodule

// File: tb/pd_dual_lock_test.sv
module pd_dual_lock_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] fr_v = '0, fp_v = '0, sl_v = '0, pol_v = 2'b11, cs_v = '0;
    logic lds = 1'b0;
    logic [1:0] tsel = '0;
    logic src_a, snk_a, src_b, snk_b, cur_hi_a, cur_hi_b, lock_all, mon;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    int m_lk[2], m_run[2], m_mute[2];

    always #2 clk = ~clk;

    pd_dual_lock uut (
        .clk(clk), .rst(rst),
        .fr_a(fr_v[0]), .fp_a(fp_v[0]), .fr_b(fr_v[1]), .fp_b(fp_v[1]),
        .sleep_a(sl_v[0]), .sleep_b(sl_v[1]),
        .pol_a(pol_v[0]), .pol_b(pol_v[1]),
        .cs_a(cs_v[0]), .cs_b(cs_v[1]),
        .lds(lds), .tsel(tsel),
        .src_a(src_a), .snk_a(snk_a), .src_b(src_b), .snk_b(snk_b),
        .cur_hi_a(cur_hi_a), .cur_hi_b(cur_hi_b),
        .lock_all(lock_all), .mon(mon)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_lock_all();
        int ok = 1;
        for (int c = 0; c < 2; c++)
            if (!(m_lk[c] != 0 || sl_v[c])) ok = 0;
        return ok;
    endfunction

    task automatic set_sleep(input int ch, input logic v);
        @(negedge clk);
        sl_v[ch] = v;
        if (v) begin
            m_lk[ch] = 0; m_run[ch] = 0; m_mute[ch] = 1;
        end
        @(posedge clk);
    endtask

    // one comparison with signed offset e (positive: reference first)
    task automatic compare(input int ch, input int e,
                           output int n_src, output int n_snk, output int n_both);
        int mag = (e < 0) ? -e : e;
        n_src = 0; n_snk = 0; n_both = 0;
        for (int k = 0; k <= mag + 1; k++) begin
            @(negedge clk);
            fr_v[ch] = (e >= 0) ? (k == 0) : (k == mag);
            fp_v[ch] = (e >= 0) ? (k == mag) : (k == 0);
            @(posedge clk);
            #1;
            begin
                logic s, d;
                s = (ch == 0) ? src_a : src_b;
                d = (ch == 0) ? snk_a : snk_b;
                if (s && d) n_both++;
                else if (s) n_src++;
                else if (d) n_snk++;
            end
        end
        @(negedge clk);
        fr_v[ch] = 1'b0;
        fp_v[ch] = 1'b0;
    endtask

    task automatic run_and_check(input int ch, input int e);
        int ns, nk, nb, mag, e_src, e_snk, e_both, lead_src;
        string tag;
        mag = (e < 0) ? -e : e;
        compare(ch, e, ns, nk, nb);
        if (sl_v[ch]) begin
            e_src = 0; e_snk = 0; e_both = 0; tag = "R5";
        end else if (m_mute[ch] != 0) begin
            e_src = 0; e_snk = 0; e_both = 0; tag = "R6";
            m_mute[ch] = 0;
        end else begin
            lead_src = ((e > 0) == (pol_v[ch] == 1'b1));
            e_src  = (mag > 0 && lead_src != 0) ? mag : 0;
            e_snk  = (mag > 0 && lead_src == 0) ? mag : 0;
            e_both = 1;
            if (pol_v[ch] == 1'b0) tag = "R3";
            else if (e > 0) tag = "R1";
            else if (e < 0) tag = "R2";
            else tag = "R4";
            if (mag >= 3) begin
                m_lk[ch] = 0; m_run[ch] = 0;
            end else if (mag <= 1) begin
                if (m_run[ch] < 3) m_run[ch]++;
                if (m_run[ch] >= 3) m_lk[ch] = 1;
            end else begin
                m_run[ch] = 0;
            end
        end
        check(tag, $sformatf("ch%0d e=%0d source-only cycles", ch, e), ns, e_src);
        check(tag, $sformatf("ch%0d e=%0d sink-only cycles", ch, e), nk, e_snk);
        check(tag, $sformatf("ch%0d e=%0d both-high cycles", ch, e), nb, e_both);
        #1;
        check((mag >= 3) ? "R8" : "R7", $sformatf("ch%0d e=%0d merged lock (R9)", ch, e),
              int'(lock_all), exp_lock_all());
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_lk[c] = 0; m_run[c] = 0; m_mute[c] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R12
        check("R12", "reset src_a", int'(src_a), 0);
        check("R12", "reset snk_a", int'(snk_a), 0);
        check("R12", "reset src_b", int'(src_b), 0);
        check("R12", "reset snk_b", int'(snk_b), 0);
        check("R12", "reset lock_all", int'(lock_all), 0);
        @(negedge clk);
        rst = 1'b0;

        // offset sweep per loop, the other asleep
        for (int ch = 0; ch < 2; ch++) begin
            set_sleep(ch, 1'b0);
            set_sleep(1 - ch, 1'b1);
            for (int p = 1; p >= 0; p--) begin
                pol_v[ch] = p[0];
                for (int e = -6; e <= 6; e++)
                    run_and_check(ch, e);
            end
            pol_v[ch] = 1'b1;
        end

        // R5: strobes to a sleeping loop
        set_sleep(0, 1'b0);
        set_sleep(1, 1'b1);
        run_and_check(1, 2);
        run_and_check(1, -1);

        // R9: both awake, both locked, then one loses and one sleeps
        set_sleep(1, 1'b0);
        for (int i = 0; i < 4; i++) run_and_check(0, 0);
        for (int i = 0; i < 4; i++) run_and_check(1, (i % 2 == 0) ? 1 : -1);
        check("R9", "both locked", int'(lock_all), 1);
        run_and_check(1, 5);
        check("R9", "loop B far error", int'(lock_all), 0);
        set_sleep(1, 1'b1);
        #1;
        check("R9", "loop B asleep counts as locked", int'(lock_all), 1);
        set_sleep(0, 1'b1);
        #1;
        check("R9", "both asleep", int'(lock_all), 1);

        // R10: monitor taps with both loops asleep
        lds = 1'b1;
        for (int t = 0; t < 4; t++) begin
            for (int pat = 0; pat < 16; pat++) begin
                @(negedge clk);
                tsel = t[1:0];
                fr_v = pat[1:0];
                fp_v = pat[3:2];
                #1;
                check("R10", $sformatf("tap %0d pattern %0d", t, pat), int'(mon), (pat >> t) & 1);
            end
        end
        @(negedge clk);
        fr_v = '0; fp_v = '0; lds = 1'b0;
        #1;
        check("R10", "lds=0 shows merged lock", int'(mon), int'(lock_all));
        check("R10", "lds=0 merged lock value", int'(mon), 1);

        // R11
        for (int v = 0; v < 4; v++) begin
            cs_v = v[1:0];
            #1;
            check("R11", "cur_hi_a", int'(cur_hi_a), v & 1);
            check("R11", "cur_hi_b", int'(cur_hi_b), (v >> 1) & 1);
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule